// File: doc/BRIEF.md
# Block Cipher Chaining-Mode Controller

This block is a register-mapped front end for a 128-bit block-cipher engine. Software programs a control word, up to eight 32-bit key words, a four-word chaining value and a four-word input block. Writing the last input word starts one block operation. The controller then applies the selected chaining mode, gives the engine its input block, direction and key through a start/done port, and waits for the engine to finish. When the engine is done, the controller stores the four output words and the updated chaining value.

The supported modes are electronic codebook, cipher block chaining, output feedback, cipher feedback and counter. A busy flag in the control word tells software when the output words may be read. Because the chaining value can be read back after each block, software can continue a long stream across several calls. The cipher rounds and the key schedule belong to the engine, not to this block.

Top module: `cipher_mode_ctrl`

## Requirements
- R1: Reset clears every register: control, key, chaining value, input and output. After reset the busy flag reads 0.
- R2: Word addresses are: 0 control; 1..8 key words K0..K7; 9..12 chaining words C0..C3; 13..16 input words D0..D3; 17..20 output words Q0..Q3. Every writable register reads back what was written. Word 3 of a block is its most significant word and the first word of the stream. The engine key bus is {K7,...,K0}, so a 128-bit key occupies K3..K0, and the first key word goes in the highest word used.
- R3: A write to D0 starts one operation. The busy flag (control bit 7) reads 1 from the cycle after that write until the engine reports done. The output and chaining words are valid once the busy flag is 0, and exactly one start pulse goes to the engine per operation.
- R4: While busy, every register write is ignored, including a further write to D0. Such a write leaves the result, the input words and the chaining words unchanged, and it does not start a second operation.
- R5: Control bits 3:1 select the mode: 0 codebook, 1 block chaining, 2 output feedback, 3 cipher feedback, 4 counter. Codes 5 to 7 act as codebook. In codebook mode the engine processes the input block in the direction given by control bit 0 (0 encrypt, 1 decrypt), and the chaining words are left unchanged.
- R6: In block chaining mode, encryption feeds the engine the input XOR the chaining value, and the new chaining value is the output. Decryption outputs the engine result XOR the old chaining value, and the new chaining value is the input block.
- R7: In output feedback mode, the engine encrypts the chaining value. The output is that keystream XOR the input, and the keystream becomes the new chaining value.
- R8: In cipher feedback mode, the engine encrypts the chaining value and the output is that keystream XOR the input. The new chaining value is the ciphertext side: the output when encrypting, the input when decrypting.
- R9: In counter mode, the engine encrypts the chaining value and the output is that result XOR the input. The chaining value then increases by one as a 128-bit big-endian counter, wrapping from all ones to zero.
- R10: Output feedback, cipher feedback and counter modes always run the engine in the encrypt direction, whatever control bit 0 holds.
- R11: An operation that runs the engine in the decrypt direction issues its start pulse only while the engine reports a valid decryption key. Operations in the encrypt direction do not wait for that signal.
- R12: Control bits 5:4 carry the key-size code, computed as key bytes / 8 - 2 (0 = 128, 1 = 192, 2 = 256 bits), and go to the engine unchanged. Control bit 6, the request to prepare the decryption key, also goes to the engine unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Word address of the read |
| rd_data | output | 32 | Read data (combinational) |
| busy | output | 1 | An operation is in progress |
| core_start | output | 1 | One-cycle start pulse to the engine |
| core_decrypt | output | 1 | Engine direction, 1 = decrypt |
| core_key_size | output | 2 | Key-size code to the engine |
| core_prep_key | output | 1 | Request to prepare the decryption key |
| core_key | output | 256 | Key words {K7..K0} |
| core_din | output | 128 | Engine input block |
| core_done | input | 1 | Engine finished (one-cycle pulse) |
| core_dout | input | 128 | Engine result, valid with core_done |
| core_key_valid | input | 1 | Engine holds a valid decryption key |

## Verification
The bench builds the controller with its default sizes: 32-bit words, four-word blocks, eight key words and 5-bit addresses. These defaults make the whole address map reachable, and they let a chaining value of all ones exercise the full 128-bit counter carry. The engine is an invertible keyed rotation with a three-cycle latency, so busy windows are long enough for writes to land mid-operation. The bench holds the key-valid signal low to show that decrypt operations stall while stream modes proceed.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int unsigned CMC_WORD_W    = 32;
  localparam int unsigned CMC_BLK_WORDS = 4;
  localparam int unsigned CMC_KEY_WORDS = 8;
  localparam int unsigned CMC_ADDR_W    = 5;

  // control word layout
  localparam int unsigned CB_DIR   = 0;
  localparam int unsigned CB_MODE  = 1;
  localparam int unsigned CB_KSZ   = 4;
  localparam int unsigned CB_PREP  = 6;
  localparam int unsigned CB_BUSY  = 7;
  localparam int unsigned CTRL_KEEP = 7;

  typedef enum logic [2:0] {
    MODE_BOOK   = 3'd0,
    MODE_CHAIN  = 3'd1,
    MODE_OUTFB  = 3'd2,
    MODE_CIPHFB = 3'd3,
    MODE_COUNT  = 3'd4
  } chain_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ARM  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;

  function automatic logic is_stream(input logic [2:0] m);
    return (m == MODE_OUTFB) || (m == MODE_CIPHFB) || (m == MODE_COUNT);
  endfunction
endpackage

// File: rtl/cmc_regs.sv
module cmc_regs #(
  parameter int unsigned WORD_W    = cmc_pkg::CMC_WORD_W,
  parameter int unsigned BLK_WORDS = cmc_pkg::CMC_BLK_WORDS,
  parameter int unsigned KEY_WORDS = cmc_pkg::CMC_KEY_WORDS,
  parameter int unsigned ADDR_W    = cmc_pkg::CMC_ADDR_W,
  localparam int unsigned BLK_W    = WORD_W * BLK_WORDS,
  localparam int unsigned KEY_W    = WORD_W * KEY_WORDS,
  localparam int unsigned CK       = cmc_pkg::CTRL_KEEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              lock,
  input  logic              finish,
  input  logic [BLK_W-1:0]  od_next,
  input  logic [BLK_W-1:0]  iv_next,
  output logic              go,
  output logic [CK-1:0]     ctrl_bits,
  output logic [KEY_W-1:0]  key_bus,
  output logic [BLK_W-1:0]  iv_bus,
  output logic [BLK_W-1:0]  din_bus,
  output logic [BLK_W-1:0]  od_bus
);
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_KEY  = 1;
  localparam int unsigned A_IV   = A_KEY + KEY_WORDS;
  localparam int unsigned A_ID   = A_IV + BLK_WORDS;
  localparam int unsigned A_OD   = A_ID + BLK_WORDS;

  logic                            wr_ok;
  logic [CK-1:0]                   ctrl_q;
  logic [KEY_WORDS-1:0][WORD_W-1:0] key_q;
  logic [BLK_WORDS-1:0][WORD_W-1:0] iv_q;
  logic [BLK_WORDS-1:0][WORD_W-1:0] din_q;
  logic [BLK_WORDS-1:0][WORD_W-1:0] od_q;

  assign wr_ok = wr_en && !lock;
  assign go    = wr_ok && (wr_addr == ADDR_W'(A_ID));

  always_ff @(posedge clk) begin
    if (!rst_n)                                         ctrl_q <= '0;
    else if (wr_ok && wr_addr == ADDR_W'(A_CTRL))       ctrl_q <= wr_data[CK-1:0];
  end

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_key
    always_ff @(posedge clk) begin
      if (!rst_n)                                       key_q[g] <= '0;
      else if (wr_ok && wr_addr == ADDR_W'(A_KEY + g))  key_q[g] <= wr_data;
    end
  end

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_blk
    always_ff @(posedge clk) begin
      if (!rst_n)                                       iv_q[g] <= '0;
      else if (finish)                                  iv_q[g] <= iv_next[g*WORD_W +: WORD_W];
      else if (wr_ok && wr_addr == ADDR_W'(A_IV + g))   iv_q[g] <= wr_data;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                                       din_q[g] <= '0;
      else if (wr_ok && wr_addr == ADDR_W'(A_ID + g))   din_q[g] <= wr_data;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                                       od_q[g] <= '0;
      else if (finish)                                  od_q[g] <= od_next[g*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_CTRL)) rd_data = WORD_W'({lock, ctrl_q});
    for (int i = 0; i < KEY_WORDS; i++)
      if (rd_addr == ADDR_W'(A_KEY + i)) rd_data = key_q[i];
    for (int i = 0; i < BLK_WORDS; i++) begin
      if (rd_addr == ADDR_W'(A_IV + i)) rd_data = iv_q[i];
      if (rd_addr == ADDR_W'(A_ID + i)) rd_data = din_q[i];
      if (rd_addr == ADDR_W'(A_OD + i)) rd_data = od_q[i];
    end
  end

  assign ctrl_bits = ctrl_q;
  assign key_bus   = key_q;
  assign iv_bus    = iv_q;
  assign din_bus   = din_q;
  assign od_bus    = od_q;
endmodule

// File: rtl/cmc_chain.sv
module cmc_chain #(
  parameter int unsigned BLK_W = cmc_pkg::CMC_WORD_W * cmc_pkg::CMC_BLK_WORDS
) (
  input  logic [2:0]       mode,
  input  logic             dir_dec,
  input  logic [BLK_W-1:0] data,
  input  logic [BLK_W-1:0] iv,
  input  logic [BLK_W-1:0] result,
  output logic [BLK_W-1:0] feed,
  output logic             feed_dec,
  output logic [BLK_W-1:0] out_blk,
  output logic [BLK_W-1:0] iv_next
);
  import cmc_pkg::*;

  function automatic logic [BLK_W-1:0] pick_feed(input logic [2:0] m, input logic dec,
                                                 input logic [BLK_W-1:0] d, input logic [BLK_W-1:0] c);
    if (is_stream(m))                return c;
    else if (m == MODE_CHAIN && !dec) return d ^ c;
    else                              return d;
  endfunction

  function automatic logic [BLK_W-1:0] pick_out(input logic [2:0] m, input logic dec,
                                                input logic [BLK_W-1:0] d, input logic [BLK_W-1:0] c,
                                                input logic [BLK_W-1:0] r);
    if (is_stream(m))                 return r ^ d;
    else if (m == MODE_CHAIN && dec)  return r ^ c;
    else                              return r;
  endfunction

  function automatic logic [BLK_W-1:0] count_up(input logic [BLK_W-1:0] v);
    return v + BLK_W'(1);
  endfunction

  function automatic logic [BLK_W-1:0] pick_chain(input logic [2:0] m, input logic dec,
                                                  input logic [BLK_W-1:0] d, input logic [BLK_W-1:0] c,
                                                  input logic [BLK_W-1:0] r);
    case (m)
      MODE_CHAIN:  return dec ? d : r;
      MODE_OUTFB:  return r;
      MODE_CIPHFB: return dec ? d : (r ^ d);
      MODE_COUNT:  return count_up(c);
      default:     return c;
    endcase
  endfunction

  assign feed     = pick_feed(mode, dir_dec, data, iv);
  assign feed_dec = dir_dec && !is_stream(mode);
  assign out_blk  = pick_out(mode, dir_dec, data, iv, result);
  assign iv_next  = pick_chain(mode, dir_dec, data, iv, result);
endmodule

// File: rtl/cmc_seq.sv
module cmc_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic need_kv,
  input  logic key_valid,
  input  logic core_done,
  output logic busy,
  output logic core_start,
  output logic finish
);
  import cmc_pkg::*;

  seq_state_e st;
  logic       may_fire;

  assign may_fire   = !need_kv || key_valid;
  assign core_start = (st == SQ_ARM) && may_fire;
  assign finish     = (st == SQ_WAIT) && core_done;
  assign busy       = (st != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SQ_IDLE;
    else begin
      case (st)
        SQ_IDLE: if (go)        st <= SQ_ARM;
        SQ_ARM:  if (may_fire)  st <= SQ_WAIT;
        SQ_WAIT: if (core_done) st <= SQ_IDLE;
        default:                st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cipher_mode_ctrl.sv
module cipher_mode_ctrl #(
  parameter int unsigned WORD_W    = cmc_pkg::CMC_WORD_W,
  parameter int unsigned BLK_WORDS = cmc_pkg::CMC_BLK_WORDS,
  parameter int unsigned KEY_WORDS = cmc_pkg::CMC_KEY_WORDS,
  parameter int unsigned ADDR_W    = cmc_pkg::CMC_ADDR_W,
  localparam int unsigned BLK_W    = WORD_W * BLK_WORDS,
  localparam int unsigned KEY_W    = WORD_W * KEY_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              core_start,
  output logic              core_decrypt,
  output logic [1:0]        core_key_size,
  output logic              core_prep_key,
  output logic [KEY_W-1:0]  core_key,
  output logic [BLK_W-1:0]  core_din,
  input  logic              core_done,
  input  logic [BLK_W-1:0]  core_dout,
  input  logic              core_key_valid
);
  import cmc_pkg::*;

  logic                       go_w;
  logic                       finish_w;
  logic                       busy_w;
  logic [CTRL_KEEP-1:0]       ctrl_w;
  logic [2:0]                 mode_w;
  logic [BLK_W-1:0]           iv_bus_w;
  logic [BLK_W-1:0]           din_bus_w;
  logic [BLK_W-1:0]           od_bus_w;
  logic [BLK_W-1:0]           od_next_w;
  logic [BLK_W-1:0]           iv_next_w;

  assign mode_w = ctrl_w[CB_MODE +: 3];

  cmc_regs #(.WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .KEY_WORDS(KEY_WORDS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lock(busy_w), .finish(finish_w),
    .od_next(od_next_w), .iv_next(iv_next_w), .go(go_w), .ctrl_bits(ctrl_w),
    .key_bus(core_key), .iv_bus(iv_bus_w), .din_bus(din_bus_w), .od_bus(od_bus_w)
  );

  cmc_chain #(.BLK_W(BLK_W)) u_chain (
    .mode(mode_w), .dir_dec(ctrl_w[CB_DIR]), .data(din_bus_w), .iv(iv_bus_w),
    .result(core_dout), .feed(core_din), .feed_dec(core_decrypt),
    .out_blk(od_next_w), .iv_next(iv_next_w)
  );

  cmc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go_w), .need_kv(core_decrypt),
    .key_valid(core_key_valid), .core_done(core_done), .busy(busy_w),
    .core_start(core_start), .finish(finish_w)
  );

  assign busy          = busy_w;
  assign core_key_size = ctrl_w[CB_KSZ +: 2];
  assign core_prep_key = ctrl_w[CB_PREP];
endmodule

// File: rtl/cmc_checker.sv
module cmc_checker #(
  parameter int unsigned BLK_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_w,
  input logic             busy_w,
  input logic             finish_w,
  input logic             core_start,
  input logic             core_decrypt,
  input logic             core_key_valid,
  input logic [2:0]       mode_w,
  input logic [BLK_W-1:0] iv_bus_w,
  input logic [BLK_W-1:0] din_bus_w,
  input logic [BLK_W-1:0] od_bus_w
);
  // R3
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) go_w |=> busy_w);
  // R3
  pulse_inside_op_chk: assert property (@(posedge clk) disable iff (!rst_n) core_start |-> busy_w);
  // R3
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) finish_w |=> !busy_w);
  // R4
  frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !finish_w) |=> ($stable(iv_bus_w) && $stable(din_bus_w) && $stable(od_bus_w)));
  // R10
  stream_encrypts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start && (mode_w == 3'd2 || mode_w == 3'd3 || mode_w == 3'd4)) |-> !core_decrypt);
  // R11
  decrypt_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_start && core_decrypt) |-> core_key_valid);
endmodule

bind cipher_mode_ctrl cmc_checker #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_w(go_w), .busy_w(busy_w), .finish_w(finish_w),
  .core_start(core_start), .core_decrypt(core_decrypt), .core_key_valid(core_key_valid),
  .mode_w(mode_w), .iv_bus_w(iv_bus_w), .din_bus_w(din_bus_w), .od_bus_w(od_bus_w)
);

// File: tb/cipher_mode_ctrl_bench.sv
module cipher_mode_ctrl_bench;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [4:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [4:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         busy;
  logic         core_start;
  logic         core_decrypt;
  logic [1:0]   core_key_size;
  logic         core_prep_key;
  logic [255:0] core_key;
  logic [127:0] core_din;
  logic         core_done;
  logic [127:0] core_dout;
  logic         kv = 1'b1;

  int checks = 0;
  int fails = 0;
  int starts_seen = 0;
  logic last_dir = 1'b0;
  bit finished = 0;

  always #5 clk = ~clk;

  cipher_mode_ctrl u_cipher_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .core_start(core_start),
    .core_decrypt(core_decrypt), .core_key_size(core_key_size), .core_prep_key(core_prep_key),
    .core_key(core_key), .core_din(core_din), .core_done(core_done), .core_dout(core_dout),
    .core_key_valid(kv)
  );

  // toy keyed permutation standing in for the cipher engine
  function automatic logic [127:0] tenc(input logic [127:0] x, input logic [127:0] k);
    logic [127:0] t;
    t = x ^ k;
    return {t[114:0], t[127:115]};
  endfunction
  function automatic logic [127:0] tdec(input logic [127:0] y, input logic [127:0] k);
    return {y[12:0], y[127:13]} ^ k;
  endfunction

  int cm_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      cm_cnt <= 0; core_done <= 1'b0; core_dout <= '0;
    end else begin
      core_done <= 1'b0;
      if (core_start) begin
        cm_cnt <= LAT;
        starts_seen <= starts_seen + 1;
        last_dir <= core_decrypt;
        core_dout <= core_decrypt ? tdec(core_din, core_key[127:0] ^ core_key[255:128])
                                  : tenc(core_din, core_key[127:0] ^ core_key[255:128]);
      end else if (cm_cnt != 0) begin
        cm_cnt <= cm_cnt - 1;
        if (cm_cnt == 1) core_done <= 1'b1;
      end
    end
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  function automatic logic [31:0] ctl(input logic dec, input logic [2:0] m,
                                      input logic [1:0] ksz, input logic prep);
    return {25'd0, prep, ksz, m, dec};
  endfunction

  logic [255:0] cur_key;
  function automatic logic [127:0] fk();
    return cur_key[127:0] ^ cur_key[255:128];
  endfunction

  task automatic load_key(input logic [255:0] k);
    for (int i = 0; i < 8; i++) bus_write(5'(1 + i), k[i*32 +: 32]);
    cur_key = k;
  endtask
  task automatic load_iv(input logic [127:0] v);
    for (int i = 0; i < 4; i++) bus_write(5'(9 + i), v[i*32 +: 32]);
  endtask
  task automatic load_block(input logic [127:0] d);
    for (int i = 3; i >= 0; i--) bus_write(5'(13 + i), d[i*32 +: 32]);
  endtask
  task automatic read_blk(input logic [4:0] base, output logic [127:0] v);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) begin bus_read(5'(base + i), w); v[i*32 +: 32] = w; end
  endtask
  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy === 1'b1 && n < 1000) begin @(negedge clk); n++; end
    if (n >= 1000) check({tag, " timeout"}, 1, 0);
  endtask

  task automatic ref_step(input logic [2:0] m, input logic dec, input logic [127:0] d,
                          input logic [127:0] iv, output logic [127:0] o, output logic [127:0] niv);
    logic [127:0] ks;
    ks = tenc(iv, fk());
    case (m)
      3'd1: if (!dec) begin o = tenc(d ^ iv, fk()); niv = o; end
            else begin o = tdec(d, fk()) ^ iv; niv = d; end
      3'd2: begin o = ks ^ d; niv = ks; end
      3'd3: begin o = ks ^ d; niv = dec ? d : o; end
      3'd4: begin o = ks ^ d; niv = iv + 128'd1; end
      default: begin o = dec ? tdec(d, fk()) : tenc(d, fk()); niv = iv; end
    endcase
  endtask

  task automatic run_op(input string tag, input logic [2:0] m, input logic dec,
                        input logic [127:0] d, input logic [127:0] iv);
    logic [127:0] o, niv, got;
    ref_step(m, dec, d, iv, o, niv);
    load_block(d);
    wait_idle(tag);
    read_blk(5'd17, got); check({tag, " output"}, got, o);
    read_blk(5'd9, got);  check({tag, " chain"}, got, niv);
  endtask

  task automatic t_reset();
    logic [31:0] w;
    bus_read(5'd0, w);  check("R1 ctrl", w, 0);
    bus_read(5'd8, w);  check("R1 key", w, 0);
    bus_read(5'd12, w); check("R1 iv", w, 0);
    bus_read(5'd17, w); check("R1 out", w, 0);
    check("R1 busy", busy, 0);
  endtask

  task automatic t_regs();
    logic [31:0] w;
    logic [255:0] k;
    k = {32'h0f1e2d3c, 32'h4b5a6978, 32'h8796a5b4, 32'hc3d2e1f0,
         32'h01234567, 32'h89abcdef, 32'hfedcba98, 32'h76543210};
    load_key(k);
    bus_read(5'd8, w); check("R2 K7 readback", w, 32'h0f1e2d3c);
    bus_read(5'd1, w); check("R2 K0 readback", w, 32'h76543210);
    check("R2 key bus", core_key, k);
    bus_write(5'd0, ctl(1'b0, 3'd0, 2'd2, 1'b1));
    bus_read(5'd0, w); check("R2 ctrl readback", w, 32'h00000060);
    check("R12 key size", core_key_size, 2);
    check("R12 prep", core_prep_key, 1);
  endtask

  task automatic t_book();
    logic [127:0] d = 128'h00112233_44556677_8899aabb_ccddeeff;
    logic [127:0] o, niv, got;
    int s0;
    load_iv(128'h5);
    bus_write(5'd0, ctl(1'b0, 3'd0, 2'd0, 1'b0));
    s0 = starts_seen;
    ref_step(3'd0, 1'b0, d, 128'h5, o, niv);
    load_block(d);
    #1 check("R3 busy after start", busy, 1);
    wait_idle("R3");
    check("R3 one start", starts_seen - s0, 1);
    read_blk(5'd17, got); check("R5 book encrypt", got, o);
    read_blk(5'd9, got);  check("R5 chain kept", got, 128'h5);
    bus_write(5'd0, ctl(1'b1, 3'd0, 2'd0, 1'b0));
    run_op("R5 book decrypt", 3'd0, 1'b1, o, 128'h5);
    bus_write(5'd0, ctl(1'b0, 3'd6, 2'd0, 1'b0));
    run_op("R5 code 6 as book", 3'd0, 1'b0, d, 128'h5);
  endtask

  task automatic t_chain();
    logic [127:0] iv0 = 128'hdeadbeef_00000000_cafef00d_12345678;
    logic [127:0] p0 = 128'h1, p1 = 128'hffff0000_ffff0000_ffff0000_ffff0000;
    logic [127:0] c0, c1, n0, n1;
    load_iv(iv0);
    bus_write(5'd0, ctl(1'b0, 3'd1, 2'd0, 1'b0));
    ref_step(3'd1, 1'b0, p0, iv0, c0, n0);
    run_op("R6 chain enc 1", 3'd1, 1'b0, p0, iv0);
    ref_step(3'd1, 1'b0, p1, n0, c1, n1);
    run_op("R6 chain enc 2", 3'd1, 1'b0, p1, n0);
    load_iv(iv0);
    bus_write(5'd0, ctl(1'b1, 3'd1, 2'd0, 1'b0));
    run_op("R6 chain dec 1", 3'd1, 1'b1, c0, iv0);
    run_op("R6 chain dec 2", 3'd1, 1'b1, c1, c0);
  endtask

  task automatic t_stream();
    logic [127:0] iv0 = 128'h0badc0de_0badc0de_0badc0de_0badc0de;
    int s0;
    kv = 1'b0;
    load_iv(iv0);
    bus_write(5'd0, ctl(1'b1, 3'd2, 2'd0, 1'b0));
    run_op("R7 outfb", 3'd2, 1'b0, 128'h77, iv0);
    check("R10 outfb engine encrypt", last_dir, 0);
    load_iv(iv0);
    bus_write(5'd0, ctl(1'b0, 3'd3, 2'd0, 1'b0));
    run_op("R8 ciphfb enc", 3'd3, 1'b0, 128'h99, iv0);
    load_iv(iv0);
    bus_write(5'd0, ctl(1'b1, 3'd3, 2'd0, 1'b0));
    s0 = starts_seen;
    run_op("R8 ciphfb dec", 3'd3, 1'b1, 128'h99, iv0);
    check("R10 ciphfb engine encrypt", last_dir, 0);
    check("R11 no wait when encrypting", starts_seen - s0, 1);
    load_iv('1);
    bus_write(5'd0, ctl(1'b1, 3'd4, 2'd0, 1'b0));
    run_op("R9 counter wrap", 3'd4, 1'b0, 128'h1234, '1);
    check("R10 counter engine encrypt", last_dir, 0);
    run_op("R9 counter step", 3'd4, 1'b0, 128'h5678, 128'h0);
    kv = 1'b1;
  endtask

  task automatic t_busy_ignore();
    logic [127:0] d = 128'haaaa5555_aaaa5555_aaaa5555_aaaa5555;
    logic [127:0] o, niv, got;
    logic [31:0] w;
    int s0;
    load_iv(128'h3);
    bus_write(5'd0, ctl(1'b0, 3'd0, 2'd0, 1'b0));
    ref_step(3'd0, 1'b0, d, 128'h3, o, niv);
    s0 = starts_seen;
    load_block(d);
    bus_write(5'd13, 32'h11111111);
    bus_write(5'd12, 32'h22222222);
    wait_idle("R4");
    repeat (LAT + 3) @(negedge clk);
    check("R4 single start", starts_seen - s0, 1);
    read_blk(5'd17, got); check("R4 output intact", got, o);
    bus_read(5'd13, w); check("R4 input word kept", w, d[31:0]);
    bus_read(5'd12, w); check("R4 chain word kept", w, 0);
  endtask

  task automatic t_key_wait();
    logic [127:0] d = 128'hc0ffee;
    logic [127:0] o, niv, got;
    int s0;
    kv = 1'b0;
    bus_write(5'd0, ctl(1'b1, 3'd0, 2'd0, 1'b1));
    ref_step(3'd0, 1'b1, d, 128'h0, o, niv);
    s0 = starts_seen;
    load_block(d);
    repeat (10) @(negedge clk);
    check("R11 stalled busy", busy, 1);
    check("R11 no start without key", starts_seen - s0, 0);
    kv = 1'b1;
    wait_idle("R11");
    check("R11 started after key", starts_seen - s0, 1);
    read_blk(5'd17, got); check("R11 result", got, o);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_book();
    t_chain();
    t_stream();
    t_busy_ignore();
    t_key_wait();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule